// File: doc/BRIEF.md
# Address-Pattern Memory Self-Test Controller

This block is a built-in test engine for a single-port synchronous RAM. A one-cycle start pulse sets it running. It then drives the RAM through two data passes over a fixed address window, from address 1 up to the top address of the array. Address 0 is never touched, so it can hold content that must survive the test.

The first pass stores each address as its own data, walking upward, and then reads the whole window back upward. The second pass stores the bitwise complement of each address, walking downward, and then reads it back upward. Every read is checked against the pattern expected at that address. The controller allows one cycle between issuing a read address and comparing the returned word.

The engine stops on the first mismatch. It holds the address that failed and raises a fail flag. In every case it ends with a single-cycle done pulse. An 8-bit status vector shows progress: bit 3 lights while the test runs, and on a clean finish bit 4 lights and bit 3 goes dark.

Top module: `mbist_engine`

## Requirements
- R1: While and directly after reset, busy, done, fail and ram_we are 0, fail_addr is 0 and all led bits are 0.
- R2: A start pulse while idle raises busy from the next cycle on, sets led bit 3 and clears led bit 4; while busy, led bit 3 is 1 and led bit 4 is 0.
- R3: In the cycles 0 to N-1 after the start edge (N = 2^ADDR_W - 1, with 0x3FFF the top address at default size), the engine writes addresses 1, 2, ... up to the top address, one per cycle, with ram_wdata equal to the address zero-extended to 16 bits; address 0 is never driven.
- R4: In the next N cycles it issues reads with ram_we = 0 to addresses 1 up to the top address. It compares the word returned on ram_rdata one cycle later with the address value.
- R5: In the next N cycles it writes addresses from the top address down to 1. Each data word is the 16-bit complement of the zero-extended address (for example, address 0x0010 gets 0xFFEF).
- R6: In the next N cycles it reads addresses 1 up to the top address and compares each returned word with the complemented address.
- R7: When a read issued in cycle k returns a wrong word, fail rises, fail_addr holds that read's address, and busy falls in cycle k+2, with done high in the same cycle. fail and fail_addr are cleared at the next start and do not change while busy.
- R8: On a clean run, done is high in cycle 4N+1 after the start edge. done is high for exactly one cycle, and busy is 0 in that cycle.
- R9: After a clean run, led bit 4 is 1 and led bit 3 is 0, fail is 0, and all other led bits remain 0.
- R10: After a failing run, led bit 3 stays 1 and led bit 4 stays 0.
- R11: A start pulse while busy is ignored: the access sequence and the completion cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin the test |
| ram_addr | output | ADDR_W (14) | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DATA_W (16) | RAM write data |
| ram_rdata | input | DATA_W (16) | RAM read data, valid one cycle after the address |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | A mismatch was found in the last run |
| fail_addr | output | ADDR_W (14) | Address of the first mismatch |
| led | output | LED_W (8) | Status vector: bit 3 running, bit 4 passed |

## Verification
The bench runs the engine against a behavioural RAM under three patterns, with a reference model checking every access. A fault-free RAM exercises the full four-phase order and the exact completion cycle; a restart pulse is injected partway through this run. A bit forced to 1 at address 4 is caught during the first read pass, which confirms that the upward address pattern detects it and that the engine stops at the right cycle. Bit 15 stuck at 0 at address 0x0010 cannot be seen in the first pass, where that bit is 0. It is caught only by the complemented second pass, which separates the two passes' coverage. A marker word in address 0 shows that the skipped location is left untouched.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WR_UP,
        PH_RD_UP,
        PH_WR_DN,
        PH_RD_DN,
        PH_DRAIN
    } phase_t;

    localparam int LED_RUN_BIT  = 3;
    localparam int LED_PASS_BIT = 4;

    function automatic logic phase_writes(input phase_t ph);
        return (ph == PH_WR_UP) || (ph == PH_WR_DN);
    endfunction

    function automatic logic phase_reads(input phase_t ph);
        return (ph == PH_RD_UP) || (ph == PH_RD_DN);
    endfunction

    function automatic logic phase_inverts(input phase_t ph);
        return (ph == PH_WR_DN) || (ph == PH_RD_DN);
    endfunction

endpackage

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step_up) begin
            addr_q <= addr_q + 1'b1;
        end else if (step_dn) begin
            addr_q <= addr_q - 1'b1;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              issue_inv,
    input  logic [DATA_W-1:0] rdata,
    output logic              mismatch,
    output logic [ADDR_W-1:0] mis_addr
);
    localparam int PAD_W = DATA_W - ADDR_W;

    typedef struct packed {
        logic              vld;
        logic              inv;
        logic [ADDR_W-1:0] addr;
    } rd_tag_t;

    rd_tag_t           tag_q;
    logic [DATA_W-1:0] expect_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q.vld  <= issue;
            tag_q.inv  <= issue_inv;
            tag_q.addr <= issue_addr;
        end
    end

    always_comb begin
        expect_w = {{PAD_W{1'b0}}, tag_q.addr};
        if (tag_q.inv) begin
            expect_w = ~expect_w;
        end
    end

    assign mismatch = tag_q.vld && (rdata != expect_w);
    assign mis_addr = tag_q.addr;
endmodule

// File: rtl/mbist_status.sv
module mbist_status
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int LED_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              finish_ok,
    input  logic              finish_bad,
    input  logic [ADDR_W-1:0] bad_addr,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [LED_W-1:0]  led
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            led       <= '0;
        end else begin
            done <= finish_ok || finish_bad;
            if (launch) begin
                fail              <= 1'b0;
                fail_addr         <= '0;
                led[LED_RUN_BIT]  <= 1'b1;
                led[LED_PASS_BIT] <= 1'b0;
            end
            if (finish_ok) begin
                led[LED_RUN_BIT]  <= 1'b0;
                led[LED_PASS_BIT] <= 1'b1;
            end
            if (finish_bad) begin
                fail      <= 1'b1;
                fail_addr <= bad_addr;
            end
        end
    end
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 16,
    parameter int LED_W   = 8,
    parameter int ADDR_LO = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [LED_W-1:0]  led
);
    localparam int                PAD_W = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(ADDR_LO);
    localparam logic [ADDR_W-1:0] HI_A  = '1;

    phase_t            phase_q, phase_d;
    logic [ADDR_W-1:0] addr;
    logic              ld, step_up, step_dn;
    logic [ADDR_W-1:0] ld_val;
    logic              at_lo, at_hi;
    logic              launch, finish_ok, mismatch, issue;
    logic [ADDR_W-1:0] mis_addr;
    logic [DATA_W-1:0] pattern;

    assign at_lo  = (addr == LO_A);
    assign at_hi  = (addr == HI_A);
    assign launch = start && (phase_q == PH_IDLE);

    always_comb begin
        phase_d   = phase_q;
        ld        = 1'b0;
        ld_val    = LO_A;
        step_up   = 1'b0;
        step_dn   = 1'b0;
        finish_ok = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_WR_UP;
                    ld      = 1'b1;
                end
            end
            PH_WR_UP: begin
                if (at_hi) begin
                    phase_d = PH_RD_UP;
                    ld      = 1'b1;
                end else begin
                    step_up = 1'b1;
                end
            end
            PH_RD_UP: begin
                if (at_hi) begin
                    phase_d = PH_WR_DN;
                    ld      = 1'b1;
                    ld_val  = HI_A;
                end else begin
                    step_up = 1'b1;
                end
            end
            PH_WR_DN: begin
                if (at_lo) begin
                    phase_d = PH_RD_DN;
                    ld      = 1'b1;
                end else begin
                    step_dn = 1'b1;
                end
            end
            PH_RD_DN: begin
                if (at_hi) begin
                    phase_d = PH_DRAIN;
                end else begin
                    step_up = 1'b1;
                end
            end
            PH_DRAIN: begin
                phase_d   = PH_IDLE;
                finish_ok = 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
        if (mismatch) begin
            phase_d   = PH_IDLE;
            finish_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    mbist_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .addr     (addr)
    );

    assign issue = phase_reads(phase_q) && !mismatch;

    mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .issue_addr (addr),
        .issue_inv  (phase_inverts(phase_q)),
        .rdata      (ram_rdata),
        .mismatch   (mismatch),
        .mis_addr   (mis_addr)
    );

    mbist_status #(.ADDR_W(ADDR_W), .LED_W(LED_W)) u_status (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .finish_ok  (finish_ok),
        .finish_bad (mismatch),
        .bad_addr   (mis_addr),
        .done       (done),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .led        (led)
    );

    always_comb begin
        pattern = {{PAD_W{1'b0}}, addr};
        if (phase_inverts(phase_q)) begin
            pattern = ~pattern;
        end
    end

    assign ram_addr  = addr;
    assign ram_we    = phase_writes(phase_q);
    assign ram_wdata = pattern;
    assign busy      = (phase_q != PH_IDLE);
endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
    parameter int ADDR_W  = 14,
    parameter int LED_W   = 8,
    parameter int ADDR_LO = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_we,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [LED_W-1:0]  led
);
    p_we_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> busy);

    p_addr_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (int'(ram_addr) >= ADDR_LO));

    p_idle_starts_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_led_running_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (led[3] && !led[4]));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_led_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> (led[4] && !led[3]));

    p_led_fail_r10: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (led[3] && !led[4]));

    p_fail_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> ($stable(fail_addr) && !fail));
endmodule

bind mbist_engine mbist_engine_chk #(
    .ADDR_W  (ADDR_W),
    .LED_W   (LED_W),
    .ADDR_LO (ADDR_LO)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .led       (led)
);

// File: tb/test_mbist_engine.sv
module test_mbist_engine;
    localparam int AW = 14;
    localparam int DW = 16;
    localparam int N  = (1 << AW) - 1;
    localparam int HI = N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [7:0]    led;

    int n_cmp = 0;
    int n_bad = 0;
    int wd    = 0;

    int          flt_a = -1;
    logic [15:0] flt_and = 16'hFFFF;
    logic [15:0] flt_or  = 16'h0000;

    logic [DW-1:0] mem [0:(1<<AW)-1];

    always #2 clk = ~clk;

    mbist_engine i_mbist_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .busy      (busy),
        .done      (done),
        .fail      (fail),
        .fail_addr (fail_addr),
        .led       (led)
    );

    function automatic logic [15:0] faulty(input int a, input logic [15:0] d);
        if (a == flt_a) return (d & flt_and) | flt_or;
        return d;
    endfunction

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= faulty(int'(ram_addr), ram_wdata);
        ram_rdata <= mem[ram_addr];
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 190000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One test run; the fault model is set beforehand. The reference is
    // derived from the phase order: W up, R up, W down (~a), R up (~a).
    task automatic run_test(input bit restart_mid);
        int   exp_end = 4 * N + 1;
        int   exp_fa  = 0;
        bit   found   = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; ; c++) begin
            if (c < exp_end) begin
                chk(busy == 1'b1, "R2", "busy", busy, 1);
                chk(led == 8'h08, "R2", "led while running", led, 8'h08);
                chk(fail == 1'b0, "R7", "fail cleared while busy", fail, 0);
                chk(done == 1'b0, "R8", "done early", done, 0);
                if (c < 4 * N) begin
                    int          a;
                    bit          wr;
                    logic [15:0] d;
                    string       rq;
                    if (c < N) begin
                        a = c + 1; wr = 1; d = 16'(a); rq = "R3";
                    end else if (c < 2 * N) begin
                        a = c - N + 1; wr = 0; d = 16'(a); rq = "R4";
                    end else if (c < 3 * N) begin
                        a = HI - (c - 2 * N); wr = 1; d = ~16'(a); rq = "R5";
                    end else begin
                        a = c - 3 * N + 1; wr = 0; d = ~16'(a); rq = "R6";
                    end
                    chk(ram_we == wr, rq, "ram_we", ram_we, wr);
                    chk(int'(ram_addr) == a, rq, "ram_addr", ram_addr, a);
                    if (wr) chk(ram_wdata == d, rq, "ram_wdata", ram_wdata, d);
                    if (!wr && !found && faulty(a, d) != d) begin
                        found   = 1;
                        exp_end = c + 2;
                        exp_fa  = a;
                    end
                end
            end else begin
                chk(done == 1'b1, found ? "R7" : "R8", "done at end cycle", done, 1);
                chk(busy == 1'b0, "R8", "busy at done", busy, 0);
                chk(fail == found, "R7", "fail flag", fail, found);
                chk(int'(fail_addr) == (found ? exp_fa : 0), "R7", "fail_addr", fail_addr,
                    found ? exp_fa : 0);
                if (found)
                    chk(led == 8'h08, "R10", "led after failure", led, 8'h08);
                else
                    chk(led == 8'h10, "R9", "led after pass", led, 8'h10);
                break;
            end
            if (restart_mid && c == 100) start = 1'b1;   // R11 stimulus
            if (c == 101) start = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single cycle", done, 0);
        chk(busy == 1'b0, "R8", "stays idle", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0;
        mem[0] = 16'hA5A5;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && fail == 0 && ram_we == 0, "R1", "flags in reset",
            {busy, done, fail, ram_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(led == 8'h00, "R1", "led after reset", led, 0);
        chk(fail_addr == 0, "R1", "fail_addr after reset", fail_addr, 0);
        chk(busy == 0 && ram_we == 0, "R1", "idle after reset", {busy, ram_we}, 0);

        // Clean RAM, with a restart pulse mid-run (R11)
        run_test(1'b1);
        chk(mem[0] == 16'hA5A5, "R3", "address 0 untouched", mem[0], 16'hA5A5);
        chk(mem[5] == ~16'h0005, "R5", "pass two content", mem[5], ~16'h0005);

        // Bit 0 stuck at 1 at address 4: caught in pass one
        flt_a = 4; flt_and = 16'hFFFF; flt_or = 16'h0001;
        run_test(1'b0);

        // Bit 15 stuck at 0 at address 0x10: visible only in pass two
        flt_a = 16; flt_and = 16'h7FFF; flt_or = 16'h0000;
        run_test(1'b0);
        chk(mem[0] == 16'hA5A5, "R3", "address 0 untouched after faults", mem[0], 16'hA5A5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule